// File: doc/BRIEF.md
# Pseudo-Fault Error Injection Controller

This controller lets fault-handling software be exercised without real hardware faults. Software loads a configuration word: an arm bit, an error class, a repeat bit and a countdown value. While armed and with error detection enabled, the countdown falls by one each clock. Once it is at zero, the next cacheable access is treated as if a protection checker had flagged it. The controller then raises an error interrupt, writes an error record holding the class, a valid bit and a flag that tells injected from real, and raises an abort when the class needs one.

The RAM arrays and the real checkers stay outside this block. Read data passes straight through the block and is never changed. Real error indications come in on their own port and are recorded whether or not an injection is pending. If a real error and an injection land on the same access, one record is written. A real uncorrectable error wins over the injected one, and the injected error wins over a real corrected one.

Top module: `fault_inject_ctrl`

## Requirements
- R1: After reset, irq_o, abort_o, rec_valid_o and rec_injected_o are 0, rec_class_o is 0, and no injection is armed.
- R2: A cycle with cfg_we_i high loads arm, class, repeat and count. After that, the count drops by one on every clock edge while it is armed, detect_en_i is high and the count is non-zero. The count holds while detect_en_i is low.
- R3: An injection fires on an edge where all of the following hold: the controller is armed, detect_en_i is high, the count is zero, acc_valid_i is high and acc_cacheable_i is high. A non-cacheable access never fires and never consumes the injection.
- R4: A recorded event (injected or real) is reported one cycle after the access edge. irq_o is high for exactly that cycle. rec_valid_o goes to 1, and rec_class_o and rec_injected_o are updated.
- R5: Class encoding: 0 = corrected, 1 = deferred, 2 = uncontainable, 3 = recoverable. abort_o pulses with irq_o exactly when the recorded class is 1, 2 or 3, and never for class 0.
- R6: On one access, a real error of class 1 to 3 is recorded with rec_injected_o = 0 even if an injection fires. Otherwise a firing injection is recorded with rec_injected_o = 1. A real class-0 error alone is recorded with rec_injected_o = 0.
- R7: With the repeat bit clear, the controller disarms after firing, and later accesses raise no injected error.
- R8: With the repeat bit set, firing reloads the count with the programmed value and the controller stays armed.
- R9: acc_rdata_o always equals acc_rdata_i in the same cycle (default unregistered variant), including on injected accesses.
- R10: rec_clr_i clears rec_valid_o on the next edge unless an event is recorded on that same edge.
- R11: While detect_en_i is low, neither injected nor real errors raise irq_o, abort_o or a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| detect_en_i | input | 1 | Error detection and reporting enable |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_arm_i | input | 1 | Arm injection |
| cfg_repeat_i | input | 1 | Reload countdown after firing |
| cfg_class_i | input | 2 | Class to inject |
| cfg_count_i | input | CNT_W | Countdown start value |
| acc_valid_i | input | 1 | Access presented this cycle |
| acc_cacheable_i | input | 1 | Access is cacheable |
| acc_rdata_i | input | DATA_W | Read data from the array |
| acc_rdata_o | output | DATA_W | Read data to the consumer, unchanged |
| real_err_i | input | 1 | Real checker flagged this access |
| real_class_i | input | 2 | Class of the real error |
| rec_clr_i | input | 1 | Clear record valid |
| irq_o | output | 1 | Error interrupt pulse |
| abort_o | output | 1 | Abort pulse |
| rec_valid_o | output | 1 | Record holds an event |
| rec_class_o | output | 2 | Recorded class |
| rec_injected_o | output | 1 | Record came from injection |

## Verification
The checker watches several things on every cycle. An abort only appears together with an interrupt and a non-corrected class. Idle, non-cacheable and detection-off cycles raise no interrupt. A real uncorrectable error always owns the record, a clear with no access empties the record, and read data is never altered. Only the bench scenarios can show that the countdown lands on the right access, that one-shot and repeat behave differently on back-to-back accesses, and that the count freezes while detection is off.

// File: rtl/fi_pkg.sv
package fi_pkg;
   typedef enum logic [1:0] {
      ERR_CORR   = 2'd0,
      ERR_DEFER  = 2'd1,
      ERR_UNCONT = 2'd2,
      ERR_RECOV  = 2'd3
   } err_class_e;

   typedef struct packed {
      logic       valid;
      err_class_e cls;
      logic       injected;
   } err_evt_t;

   function automatic logic needs_abort(input err_class_e c);
      return c != ERR_CORR;
   endfunction
endpackage

// File: rtl/fi_countdown.sv
module fi_countdown #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             load_i,
   input  logic             arm_i,
   input  logic             repeat_i,
   input  logic [1:0]       class_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             fire_i,
   output logic             ready_o,
   output logic [1:0]       class_o
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             armed_q;
   logic             rep_q;
   logic [1:0]       cls_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q  <= 1'b0;
         rep_q    <= 1'b0;
         cls_q    <= 2'd0;
         cnt_q    <= ZERO;
         reload_q <= ZERO;
      end else if (load_i) begin
         armed_q  <= arm_i;
         rep_q    <= repeat_i;
         cls_q    <= class_i;
         cnt_q    <= count_i;
         reload_q <= count_i;
      end else if (fire_i) begin
         if (rep_q) cnt_q <= reload_q;
         else       armed_q <= 1'b0;
      end else if (armed_q && en_i && cnt_q != ZERO) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign ready_o = armed_q && (cnt_q == ZERO);
   assign class_o = cls_q;
endmodule

// File: rtl/fi_arbiter.sv
module fi_arbiter
   import fi_pkg::*;
(
   input  logic     inj_fire_i,
   input  logic [1:0] inj_class_i,
   input  logic     real_hit_i,
   input  logic [1:0] real_class_i,
   output err_evt_t evt_o
);
   err_class_e inj_c;
   err_class_e real_c;

   always_comb begin
      inj_c  = err_class_e'(inj_class_i);
      real_c = err_class_e'(real_class_i);
      evt_o  = '{valid: 1'b0, cls: ERR_CORR, injected: 1'b0};
      if (real_hit_i && needs_abort(real_c)) begin
         evt_o = '{valid: 1'b1, cls: real_c, injected: 1'b0};
      end else if (inj_fire_i) begin
         evt_o = '{valid: 1'b1, cls: inj_c, injected: 1'b1};
      end else if (real_hit_i) begin
         evt_o = '{valid: 1'b1, cls: real_c, injected: 1'b0};
      end
   end
endmodule

// File: rtl/fi_record.sv
module fi_record
   import fi_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  err_evt_t   evt_i,
   input  logic       clr_i,
   output logic       irq_o,
   output logic       abort_o,
   output logic       valid_o,
   output logic [1:0] class_o,
   output logic       injected_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_o      <= 1'b0;
         abort_o    <= 1'b0;
         valid_o    <= 1'b0;
         class_o    <= 2'd0;
         injected_o <= 1'b0;
      end else begin
         irq_o   <= evt_i.valid;
         abort_o <= evt_i.valid && needs_abort(evt_i.cls);
         if (evt_i.valid) begin
            valid_o    <= 1'b1;
            class_o    <= evt_i.cls;
            injected_o <= evt_i.injected;
         end else if (clr_i) begin
            valid_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fault_inject_ctrl.sv
module fault_inject_ctrl
   import fi_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 64,
   parameter bit PIPE_DATA = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              detect_en_i,
   input  logic              cfg_we_i,
   input  logic              cfg_arm_i,
   input  logic              cfg_repeat_i,
   input  logic [1:0]        cfg_class_i,
   input  logic [CNT_W-1:0]  cfg_count_i,
   input  logic              acc_valid_i,
   input  logic              acc_cacheable_i,
   input  logic [DATA_W-1:0] acc_rdata_i,
   output logic [DATA_W-1:0] acc_rdata_o,
   input  logic              real_err_i,
   input  logic [1:0]        real_class_i,
   input  logic              rec_clr_i,
   output logic              irq_o,
   output logic              abort_o,
   output logic              rec_valid_o,
   output logic [1:0]        rec_class_o,
   output logic              rec_injected_o
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must be 1..32");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic       ready;
   logic       fire;
   logic       real_hit;
   logic [1:0] inj_class;
   err_evt_t   evt;

   assign fire     = ready && detect_en_i && acc_valid_i && acc_cacheable_i;
   assign real_hit = detect_en_i && acc_valid_i && real_err_i;

   fi_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (detect_en_i),
      .load_i   (cfg_we_i),
      .arm_i    (cfg_arm_i),
      .repeat_i (cfg_repeat_i),
      .class_i  (cfg_class_i),
      .count_i  (cfg_count_i),
      .fire_i   (fire),
      .ready_o  (ready),
      .class_o  (inj_class)
   );

   fi_arbiter u_arb (
      .inj_fire_i   (fire),
      .inj_class_i  (inj_class),
      .real_hit_i   (real_hit),
      .real_class_i (real_class_i),
      .evt_o        (evt)
   );

   fi_record u_rec (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt),
      .clr_i      (rec_clr_i),
      .irq_o      (irq_o),
      .abort_o    (abort_o),
      .valid_o    (rec_valid_o),
      .class_o    (rec_class_o),
      .injected_o (rec_injected_o)
   );

   if (PIPE_DATA) begin : g_data_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) acc_rdata_o <= '0;
         else         acc_rdata_o <= acc_rdata_i;
      end
   end else begin : g_data_wire
      assign acc_rdata_o = acc_rdata_i;
   end
endmodule

// File: rtl/fault_inject_ctrl_chk.sv
module fault_inject_ctrl_chk #(
   parameter int DATA_W    = 64,
   parameter bit PIPE_DATA = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              detect_en_i,
   input logic              acc_valid_i,
   input logic              acc_cacheable_i,
   input logic [DATA_W-1:0] acc_rdata_i,
   input logic [DATA_W-1:0] acc_rdata_o,
   input logic              real_err_i,
   input logic [1:0]        real_class_i,
   input logic              rec_clr_i,
   input logic              irq_o,
   input logic              abort_o,
   input logic              rec_valid_o,
   input logic [1:0]        rec_class_o,
   input logic              rec_injected_o
);
   AST_IRQ_HAS_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> rec_valid_o); // R4
   AST_ABORT_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> (irq_o && rec_class_o != 2'd0)); // R5
   AST_UNCORR_NEEDS_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && rec_class_o != 2'd0) |-> abort_o); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc_valid_i |=> !irq_o); // R3
   AST_NONCACHE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && !acc_cacheable_i && !real_err_i) |=> !irq_o); // R3
   AST_DETECT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !detect_en_i |=> (!irq_o && !abort_o)); // R11
   AST_REAL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (detect_en_i && acc_valid_i && real_err_i && real_class_i != 2'd0)
      |=> (!rec_injected_o && rec_class_o == $past(real_class_i))); // R6
   AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rec_clr_i && !acc_valid_i) |=> !rec_valid_o); // R10

   if (PIPE_DATA) begin : g_pipe
      AST_DATA_INTACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> acc_rdata_o == $past(acc_rdata_i)); // R9
   end else begin : g_wire
      AST_DATA_INTACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         acc_rdata_o == acc_rdata_i); // R9
   end
endmodule

bind fault_inject_ctrl fault_inject_ctrl_chk #(.DATA_W(DATA_W), .PIPE_DATA(PIPE_DATA)) u_chk (.*);

// File: tb/fault_inject_ctrl_bench.sv
module fault_inject_ctrl_bench;
   localparam int CNT_W  = 16;
   localparam int DATA_W = 64;

   typedef struct packed {
      logic       arm;
      logic [7:0] cnt;
      logic [1:0] cls;
      logic       rep;
      logic [7:0] idle;
      logic       cach;
      logic       rerr;
      logic [1:0] rcls;
      logic       e_irq;
      logic [1:0] e_cls;
      logic       e_inj;
      logic       e_abt;
   } vec_t;

   // arm cnt cls rep idle cach rerr rcls | e_irq e_cls e_inj e_abt
   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'd3, 2'd0, 1'b0, 8'd3, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0}, // R3 fire at count end
      '{1'b1, 8'd3, 2'd1, 1'b0, 8'd2, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0}, // R2 too early
      '{1'b1, 8'd0, 2'd2, 1'b0, 8'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 1'b1}, // R5 uncontainable
      '{1'b1, 8'd5, 2'd3, 1'b0, 8'd7, 1'b1, 1'b0, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1}, // R5 recoverable
      '{1'b1, 8'd2, 2'd1, 1'b0, 8'd2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0}, // R3 non-cacheable
      '{1'b1, 8'd1, 2'd0, 1'b0, 8'd1, 1'b1, 1'b1, 2'd2, 1'b1, 2'd2, 1'b0, 1'b1}, // R6 real UC wins
      '{1'b1, 8'd1, 2'd1, 1'b0, 8'd1, 1'b1, 1'b1, 2'd0, 1'b1, 2'd1, 1'b1, 1'b1}, // R6 inj beats real CE
      '{1'b1, 8'd4, 2'd0, 1'b0, 8'd0, 1'b1, 1'b1, 2'd1, 1'b1, 2'd1, 1'b0, 1'b1}, // R6 real only
      '{1'b1, 8'd0, 2'd0, 1'b0, 8'd0, 1'b1, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0}, // R6 inj CE vs real CE
      '{1'b0, 8'd0, 2'd1, 1'b0, 8'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0}  // R3 not armed
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              detect_en = 1'b1;
   logic              cfg_we = 1'b0, cfg_arm = 1'b0, cfg_rep = 1'b0;
   logic [1:0]        cfg_cls = '0;
   logic [CNT_W-1:0]  cfg_cnt = '0;
   logic              acc_valid = 1'b0, acc_cach = 1'b0;
   logic [DATA_W-1:0] rdata_in = '0;
   logic [DATA_W-1:0] rdata_out;
   logic              real_err = 1'b0;
   logic [1:0]        real_cls = '0;
   logic              rec_clr = 1'b0;
   logic              irq, abort_s, rec_valid, rec_inj;
   logic [1:0]        rec_cls;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   fault_inject_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fault_inject_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .detect_en_i(detect_en),
      .cfg_we_i(cfg_we), .cfg_arm_i(cfg_arm), .cfg_repeat_i(cfg_rep),
      .cfg_class_i(cfg_cls), .cfg_count_i(cfg_cnt),
      .acc_valid_i(acc_valid), .acc_cacheable_i(acc_cach),
      .acc_rdata_i(rdata_in), .acc_rdata_o(rdata_out),
      .real_err_i(real_err), .real_class_i(real_cls), .rec_clr_i(rec_clr),
      .irq_o(irq), .abort_o(abort_s), .rec_valid_o(rec_valid),
      .rec_class_o(rec_cls), .rec_injected_o(rec_inj)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic arm, input logic [CNT_W-1:0] cnt,
                            input logic [1:0] cls, input logic rep);
      cfg_we = 1'b1; cfg_arm = arm; cfg_cnt = cnt; cfg_cls = cls; cfg_rep = rep;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_rec();
      rec_clr = 1'b1;
      @(negedge clk);
      rec_clr = 1'b0;
   endtask

   task automatic access(input logic cach, input logic rerr, input logic [1:0] rcls);
      acc_valid = 1'b1; acc_cach = cach; real_err = rerr; real_cls = rcls;
      @(negedge clk);
      acc_valid = 1'b0; acc_cach = 1'b0; real_err = 1'b0; real_cls = '0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq", irq, 0);
      check("R1 abort", abort_s, 0);
      check("R1 rec_valid", rec_valid, 0);
      check("R1 rec_inj", rec_inj, 0);
      rst_n = 1'b1;
      @(negedge clk);
      access(1'b1, 1'b0, 2'd0);
      check("R1 no armed injection after reset", irq, 0);

      for (int i = 0; i < NV; i++) begin
         clear_rec();
         write_cfg(VEC[i].arm, CNT_W'(VEC[i].cnt), VEC[i].cls, VEC[i].rep);
         repeat (int'(VEC[i].idle)) @(negedge clk);
         access(VEC[i].cach, VEC[i].rerr, VEC[i].rcls);
         check($sformatf("R4 irq vec%0d", i), irq, VEC[i].e_irq);
         check($sformatf("R4 rec_valid vec%0d", i), rec_valid, VEC[i].e_irq);
         if (VEC[i].e_irq) begin
            check($sformatf("R6 class vec%0d", i), rec_cls, VEC[i].e_cls);
            check($sformatf("R6 injected vec%0d", i), rec_inj, VEC[i].e_inj);
         end
         check($sformatf("R5 abort vec%0d", i), abort_s, VEC[i].e_abt);
         @(negedge clk);
         check($sformatf("R4 irq single pulse vec%0d", i), irq, 0);
      end

      // R7 one-shot
      clear_rec();
      write_cfg(1'b1, '0, 2'd1, 1'b0);
      access(1'b1, 1'b0, 2'd0);
      check("R7 first fires", irq, 1);
      clear_rec();
      access(1'b1, 1'b0, 2'd0);
      check("R7 disarmed irq", irq, 0);
      check("R7 disarmed record", rec_valid, 0);

      // R8 repeat reload
      clear_rec();
      write_cfg(1'b1, CNT_W'(2), 2'd1, 1'b1);
      repeat (2) @(negedge clk);
      access(1'b1, 1'b0, 2'd0);
      check("R8 first fire", irq, 1);
      access(1'b1, 1'b0, 2'd0);
      check("R8 reloaded count blocks", irq, 0);
      @(negedge clk);
      access(1'b1, 1'b0, 2'd0);
      check("R8 second fire", irq, 1);
      check("R8 class", rec_cls, 1);

      // R11 / R2 detection off freezes count and blocks reports
      clear_rec();
      detect_en = 1'b0;
      write_cfg(1'b1, CNT_W'(2), 2'd2, 1'b0);
      repeat (5) @(negedge clk);
      access(1'b1, 1'b1, 2'd2);
      check("R11 no irq while disabled", irq, 0);
      check("R11 no record while disabled", rec_valid, 0);
      detect_en = 1'b1;
      access(1'b1, 1'b0, 2'd0);
      check("R2 count held while disabled", irq, 0);
      @(negedge clk);
      access(1'b1, 1'b0, 2'd0);
      check("R2 fires after resumed countdown", irq, 1);

      // R10 clear behaviour
      clear_rec();
      check("R10 clear", rec_valid, 0);
      write_cfg(1'b1, '0, 2'd0, 1'b0);
      rec_clr = 1'b1;
      access(1'b1, 1'b0, 2'd0);
      rec_clr = 1'b0;
      check("R10 event beats clear", rec_valid, 1);

      // R9 data untouched on injected access
      clear_rec();
      write_cfg(1'b1, '0, 2'd3, 1'b0);
      rdata_in = 64'hA5A5_0F0F_1234_5678;
      acc_valid = 1'b1; acc_cach = 1'b1;
      #1;
      check("R9 data pass-through", rdata_out, 64'hA5A5_0F0F_1234_5678);
      @(negedge clk);
      acc_valid = 1'b0; acc_cach = 1'b0;
      check("R9 injection still reported", irq, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule